// File: doc/BRIEF.md
# FM Sound Host Port and Interval Timers

This block sits between a host processor and the synthesis core of an FM sound generator. The host sees a window of four byte ports that form two address/data pairs, one for each register bank. A write to an address port selects a register number for that bank. A write to the matching data port sends the byte to the selected register. The block passes every data write on as a one-cycle strobe carrying the bank, the register number and the byte. The operator, LFO and DAC logic elsewhere capture their own settings from that strobe.

The block itself owns the global timing registers in bank 0. These are a 10-bit interval timer A, an 8-bit interval timer B, and a control register. The control register runs the timers, lets their overflows raise status flags, clears those flags and holds the channel 3 mode field. Any read returns a status byte with a busy bit and the two overflow flags. The busy bit stays high for a set number of clock cycles after each data write.

Top module: `fmhost_regs`

## Requirements
- R1: A write to offset 0 or 2 latches a register number for bank 0 or bank 1. A write to offset 1 or 3 produces, on the next cycle, a one-cycle `wr_stb` with `wr_bank` = 0 or 1, `wr_reg` = the number last latched for that bank, and `wr_data` = the byte. A latched number stays valid for any number of data writes, and address writes alone produce no strobe.
- R2: `bus_rdata` always shows the status byte, whatever `bus_addr` is. Bit 7 is busy, bit 1 is the timer B flag, bit 0 is the timer A flag, and bits 6:2 are 0. After reset the status byte is 0x00.
- R3: A data-port write raises busy from the next cycle for exactly `BUSY_CYCLES` cycles. A data write made while busy is high is still passed on and restarts the full busy period.
- R4: The timer A reload value is {reg 0x24[7:0], reg 0x25[1:0]}, and bits 7:2 of 0x25 are ignored. A running timer A with reload N overflows on its (1024−N)-th tick.
- R5: The timer B reload value is reg 0x26. A running timer B with reload N overflows on its (256−N)-th tick.
- R6: In reg 0x27, bit 0 runs timer A and bit 1 runs timer B. A stopped timer ignores `tick`. On each change from stopped to running, the timer reloads and counts its full period again. An overflow pulse only follows a tick.
- R7: Each overflow gives a one-cycle `ovf_a`/`ovf_b` pulse in every case. The status flag is set only while enable bit 2 (timer A) or bit 3 (timer B) of reg 0x27 is 1.
- R8: Writing reg 0x27 with bit 4 = 1 clears the timer A flag, and bit 5 = 1 clears the timer B flag. A 0 in either bit leaves that flag unchanged.
- R9: `ch3_mode` holds bits 7:6 of the last bank-0 write to reg 0x27 and is 0 after reset.
- R10: Writes to registers 0x24–0x27 in bank 1 are passed on as strobes, but they change neither timer, flag nor `ch3_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer step enable, one count per cycle it is high |
| bus_we | input | 1 | Host write enable |
| bus_addr | input | 2 | Port offset within the four-byte window |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Status byte |
| wr_stb | output | 1 | Register write strobe |
| wr_bank | output | 1 | Bank of the strobed write |
| wr_reg | output | 8 | Register number of the strobed write |
| wr_data | output | 8 | Data of the strobed write |
| ch3_mode | output | 2 | Stored channel 3 mode field |
| ovf_a | output | 1 | Timer A overflow pulse |
| ovf_b | output | 1 | Timer B overflow pulse |

## Verification
The bench builds the block with `BUSY_CYCLES` = 5. With that value the whole busy window can be checked cycle by cycle, including its last high cycle and the restart caused by a second write. The timer widths keep their defaults. Reload values near the all-ones maximum make overflows come within a handful of ticks, so the exact tick on which each overflow falls, the ignored upper bits of 0x25 and the reload on restart can all be checked directly. Strobes are checked by a scoreboard against the bench's own model of the two address latches.

// File: rtl/fmhost_pkg.sv
package fmhost_pkg;

    localparam int NBANK   = 2;
    localparam int TA_W    = 10;
    localparam int TB_W    = 8;
    localparam int TA_LO_W = TA_W - 8;

    localparam logic [7:0] RG_TA_HI = 8'h24;
    localparam logic [7:0] RG_TA_LO = 8'h25;
    localparam logic [7:0] RG_TB    = 8'h26;
    localparam logic [7:0] RG_CTRL  = 8'h27;

    // a register write as carried on the strobe
    typedef struct packed {
        logic       bank;
        logic [7:0] regno;
        logic [7:0] data;
    } wr_t;

    // timer control as stored from the control register
    typedef struct packed {
        logic [1:0] mode;
        logic       en_b;
        logic       en_a;
        logic       run_b;
        logic       run_a;
    } tctrl_t;

    function automatic logic [7:0] status_byte(input logic busy,
                                               input logic flag_b,
                                               input logic flag_a);
        return {busy, 5'b0, flag_b, flag_a};
    endfunction

endpackage

// File: rtl/fmhost_port_dec.sv
module fmhost_port_dec
    import fmhost_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic       data_wr,
    output logic       stb,
    output wr_t        wr
);
    logic [7:0] sel_q [NBANK];
    logic       bank;

    assign bank    = addr[1];
    assign data_wr = we && addr[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NBANK; b++) sel_q[b] <= 8'h00;
            stb <= 1'b0;
            wr  <= '0;
        end else begin
            stb <= data_wr;
            if (we && !addr[0]) sel_q[bank] <= wdata;
            if (data_wr) begin
                wr.bank  <= bank;
                wr.regno <= sel_q[bank];
                wr.data  <= wdata;
            end
        end
    end

endmodule

// File: rtl/fmhost_busy.sv
module fmhost_busy #(
    parameter int BUSY_CYCLES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= CW'(BUSY_CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/fmhost_timer.sv
module fmhost_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] reload,
    output logic         ovf
);
    logic [W-1:0] cnt;
    logic         run_q;
    logic         at_max;

    assign at_max = (cnt == {W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            run_q <= 1'b0;
            ovf   <= 1'b0;
        end else begin
            run_q <= run;
            ovf   <= 1'b0;
            if (run && !run_q) begin
                cnt <= reload;
            end else if (run && tick) begin
                if (at_max) begin
                    cnt <= reload;
                    ovf <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/fmhost_regs.sv
module fmhost_regs
    import fmhost_pkg::*;
#(
    parameter int BUSY_CYCLES = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       bus_we,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       wr_stb,
    output logic       wr_bank,
    output logic [7:0] wr_reg,
    output logic [7:0] wr_data,
    output logic [1:0] ch3_mode,
    output logic       ovf_a,
    output logic       ovf_b
);
    logic         data_wr;
    logic         stb;
    wr_t          wr;
    logic         busy;
    logic         gstb;
    logic [7:0]   ta_hi;
    logic [TA_LO_W-1:0] ta_lo;
    logic [TB_W-1:0]    tb_val;
    tctrl_t       ctl;
    logic         flag_a, flag_b;
    logic         clr_a, clr_b;

    fmhost_port_dec u_dec (
        .clk     (clk),
        .rst     (rst),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .data_wr (data_wr),
        .stb     (stb),
        .wr      (wr)
    );

    fmhost_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst   (rst),
        .start (data_wr),
        .busy  (busy)
    );

    // global registers live in bank 0 only
    assign gstb  = stb && !wr.bank;
    assign clr_a = gstb && (wr.regno == RG_CTRL) && wr.data[4];
    assign clr_b = gstb && (wr.regno == RG_CTRL) && wr.data[5];

    always_ff @(posedge clk) begin
        if (rst) begin
            ta_hi  <= '0;
            ta_lo  <= '0;
            tb_val <= '0;
            ctl    <= '0;
        end else if (gstb) begin
            case (wr.regno)
                RG_TA_HI: ta_hi  <= wr.data;
                RG_TA_LO: ta_lo  <= wr.data[TA_LO_W-1:0];
                RG_TB:    tb_val <= wr.data[TB_W-1:0];
                RG_CTRL:  ctl    <= '{mode:  wr.data[7:6],
                                      en_b:  wr.data[3],
                                      en_a:  wr.data[2],
                                      run_b: wr.data[1],
                                      run_a: wr.data[0]};
                default: ;
            endcase
        end
    end

    fmhost_timer #(.W(TA_W)) u_tmr_a (
        .clk    (clk),
        .rst    (rst),
        .run    (ctl.run_a),
        .tick   (tick),
        .reload ({ta_hi, ta_lo}),
        .ovf    (ovf_a)
    );

    fmhost_timer #(.W(TB_W)) u_tmr_b (
        .clk    (clk),
        .rst    (rst),
        .run    (ctl.run_b),
        .tick   (tick),
        .reload (tb_val),
        .ovf    (ovf_b)
    );

    // a new overflow wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_a <= 1'b0;
            flag_b <= 1'b0;
        end else begin
            if (ovf_a && ctl.en_a) flag_a <= 1'b1;
            else if (clr_a)        flag_a <= 1'b0;
            if (ovf_b && ctl.en_b) flag_b <= 1'b1;
            else if (clr_b)        flag_b <= 1'b0;
        end
    end

    assign bus_rdata = status_byte(busy, flag_b, flag_a);
    assign wr_stb    = stb;
    assign wr_bank   = wr.bank;
    assign wr_reg    = wr.regno;
    assign wr_data   = wr.data;
    assign ch3_mode  = ctl.mode;

endmodule

// File: rtl/fmhost_chk.sv
module fmhost_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       bus_we,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_rdata,
    input logic       wr_stb,
    input logic       wr_bank,
    input logic       ovf_a,
    input logic       ovf_b
);
    p_strobe_follows_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr[0]) |=> (wr_stb && wr_bank == $past(bus_addr[1])));

    p_no_stray_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr[0]) |=> !wr_stb);

    p_busy_after_write_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr[0]) |=> bus_rdata[7]);

    p_ovf_a_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
        ovf_a |-> $past(tick));

    p_ovf_b_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
        ovf_b |-> $past(tick));

    p_flag_a_source_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_rdata[0]) |-> $past(ovf_a));

    p_flag_b_source_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_rdata[1]) |-> $past(ovf_b));
endmodule

bind fmhost_regs fmhost_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .wr_stb    (wr_stb),
    .wr_bank   (wr_bank),
    .ovf_a     (ovf_a),
    .ovf_b     (ovf_b)
);

// File: tb/fmhost_regs_tb.sv
module fmhost_regs_tb;
    localparam int NB = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       wr_stb, wr_bank;
    logic [7:0] wr_reg, wr_data;
    logic [1:0] ch3_mode;
    logic       ovf_a, ovf_b;

    int total = 0;
    int bad = 0;
    int na = 0;
    int nb_cnt = 0;
    logic [7:0]  sel_m [2];
    logic [16:0] expq [$];
    bit ended = 0;

    always #10 clk = ~clk;

    fmhost_regs #(.BUSY_CYCLES(NB)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wr_stb(wr_stb), .wr_bank(wr_bank), .wr_reg(wr_reg), .wr_data(wr_data),
        .ch3_mode(ch3_mode), .ovf_a(ovf_a), .ovf_b(ovf_b)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor: scoreboard for strobes (R1) and overflow pulse counts
    always @(negedge clk) begin
        if (!rst) begin
            if (ovf_a) na++;
            if (ovf_b) nb_cnt++;
            if (wr_stb) begin
                if (expq.size() == 0) begin
                    check("R1 unexpected strobe", {wr_bank, wr_reg, wr_data}, 0);
                end else begin
                    logic [16:0] e;
                    e = expq.pop_front();
                    check("R1 strobe contents", {wr_bank, wr_reg, wr_data}, e);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        if (a[0]) expq.push_back({a[1], sel_m[a[1]], d});
        else sel_m[a[1]] = d;
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic setreg(input logic bank, input logic [7:0] r, input logic [7:0] d);
        wr({bank, 1'b0}, r);
        wr({bank, 1'b1}, d);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        sel_m[0] = 8'h00; sel_m[1] = 8'h00;
        idle(3);
        @(negedge clk) rst = 1'b0;
        check("R2 reset status", bus_rdata, 8'h00);
        check("R9 reset mode", ch3_mode, 0);
        check("R1 reset strobe", wr_stb, 0);

        // R3 busy window, status seen at every offset (R2)
        wr(2'd1, 8'h5A);
        check("R3 busy first cycle", bus_rdata[7], 1);
        for (int i = 1; i <= NB; i++) begin
            @(negedge clk);
            bus_addr = 2'(i);
            check("R3 busy window", bus_rdata[7], (i < NB) ? 1 : 0);
        end
        wr(2'd3, 8'h01);
        idle(2);
        wr(2'd3, 8'h02);
        idle(NB - 1);
        check("R3 busy restarted", bus_rdata[7], 1);
        idle(1);
        check("R3 busy ends", bus_rdata[7], 0);

        // R4 timer A reload 1020 -> overflow on 4th tick
        setreg(0, 8'h24, 8'hFF);
        setreg(0, 8'h25, 8'h00);
        setreg(0, 8'h27, 8'h05);
        idle(3);
        ticks(3); idle(2);
        check("R4 no overflow after 3 ticks", na, 0);
        check("R7 flag A still clear", bus_rdata[0], 0);
        ticks(1); idle(2);
        check("R4 overflow on 4th tick", na, 1);
        check("R2 status A flag", bus_rdata & 8'h7F, 8'h01);

        // R8 clear A, then R7 overflow without enable
        setreg(0, 8'h27, 8'h15);
        idle(3);
        check("R8 clear A flag", bus_rdata[0], 0);
        setreg(0, 8'h27, 8'h01);
        idle(3);
        ticks(4); idle(2);
        check("R7 pulse without enable", na, 2);
        check("R7 flag not set when disabled", bus_rdata[0], 0);

        // R4 low bits from 0x25, upper bits ignored: reload 1022
        setreg(0, 8'h25, 8'hFE);
        setreg(0, 8'h27, 8'h00);
        setreg(0, 8'h27, 8'h05);
        idle(3);
        ticks(1); idle(2);
        check("R4 low bits one tick", na, 2);
        ticks(1); idle(2);
        check("R4 low bits overflow", na, 3);
        check("R4 flag set", bus_rdata[0], 1);

        // R6 stopped timer ignores ticks
        setreg(0, 8'h27, 8'h10);
        idle(3);
        check("R8 clear on stop write", bus_rdata[0], 0);
        ticks(10); idle(2);
        check("R6 stopped ignores ticks", na, 3);

        // R5 timer B reload 250 -> 6 ticks
        setreg(0, 8'h26, 8'hFA);
        setreg(0, 8'h27, 8'h0A);
        idle(3);
        ticks(5); idle(2);
        check("R5 no overflow after 5 ticks", nb_cnt, 0);
        ticks(1); idle(2);
        check("R5 overflow on 6th tick", nb_cnt, 1);
        check("R5 flag B", bus_rdata & 8'h7F, 8'h02);

        // R8 zero in bit 5 keeps B flag; one clears
        setreg(0, 8'h27, 8'h1A);
        idle(3);
        check("R8 zero bit keeps flag B", bus_rdata[1], 1);
        setreg(0, 8'h27, 8'h2A);
        idle(3);
        check("R8 clear B flag", bus_rdata[1], 0);

        // R6 restart reloads
        ticks(3);
        setreg(0, 8'h27, 8'h08);
        setreg(0, 8'h27, 8'h0A);
        idle(3);
        ticks(5); idle(2);
        check("R6 reload on restart", nb_cnt, 1);
        ticks(1); idle(2);
        check("R6 full period after restart", nb_cnt, 2);

        // R9 channel 3 mode
        setreg(0, 8'h27, 8'h80);
        idle(3);
        check("R9 mode field", ch3_mode, 2);

        // R10 bank 1 write to control has no effect
        setreg(1, 8'h27, 8'h43);
        idle(3);
        check("R10 mode unchanged", ch3_mode, 2);
        ticks(8); idle(2);
        check("R10 timer A stays stopped", na, 3);
        check("R10 timer B stays stopped", nb_cnt, 2);

        // R1 latched number reused, address write alone gives no strobe
        wr(2'd3, 8'h11);
        wr(2'd3, 8'h22);
        wr(2'd0, 8'h30);
        idle(2);
        wr(2'd1, 8'h7E);
        idle(10);
        check("R1 all strobes seen", expq.size(), 0);
        finish_run();
    end

endmodule